// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the register and control layer between a byte-wide burst bus and a 128-bit block-cipher engine. Its bus window holds a control register, a 16-byte window that reaches either the key page or the data page depending on a mode field, and a mirror control register at the top of the window. The mirror register carries a start bit. One burst can therefore set the mode, load sixteen bytes and launch a run without any other access.

The block starts engine runs and captures each result into the data page. It also latches the engine's last round key for readback, while the key that software wrote stays hidden and is used again for later runs. Any access to the control register during a run cancels that run. The bus keeps its own address counter: the first byte of a burst carries the address, and each later byte goes to the next address. Read data follows the current address combinationally.

Top module: `aesreg_frontend`

## Requirements
- R1: Only byte addresses 0x82 to 0x94 respond. Address 0x82 is reserved and reads 0. Writes to 0x82 or to any address outside that range change nothing, and reads outside the range return 0.
- R2: The control byte is laid out as follows. Bit 7 is the start request, which takes effect only when written at 0x94 and always reads 0. Bits 6:4 are the mode. Bit 3 is the direction (0 encrypt, 1 decrypt). Bits 2:1 read 0. Bit 0 is the read-only busy flag. A write to 0x83 or to 0x94 updates the mode and the direction, and a read of either address returns the same byte.
- R3: Window address 0x84+i reaches byte i of a block, where byte 0 is bits 127:120. Mode 1 selects the key page and mode 0 selects the data page. With any other mode, window writes are dropped and window reads return 0.
- R4: A burst that starts at 0x83 and writes 18 bytes sets the control register, fills all 16 window bytes and writes 0x94 in one transfer.
- R5: A write of 1 to bit 7 at 0x94 while idle produces, on the next cycle, a single-cycle engine start. With it the block presents the direction from that write, the stored key page and the data page, and the busy flag is set.
- R6: When the engine reports done during a run, the data page takes the result block, the last round key is latched, and busy clears on the next cycle. A done signal while idle is ignored.
- R7: Window reads in key mode return the latched last round key once any run has completed, and the written key before that. Runs never alter the key page, and every later run is given that same written key.
- R8: A read or write of 0x83 during a run produces a single-cycle engine abort on the next cycle, together with busy clearing. The run then updates neither the data page nor the latched key, even if the engine reports done in the same cycle as the access.
- R9: While busy, window writes are dropped and a start request is ignored. The busy flag reads 1 at 0x94.
- R10: Reset clears the control fields, the busy flag, both pages, the latched key and the burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_first | input | 1 | Marks the first byte of a burst, which uses bus_addr |
| bus_strobe | input | 1 | A byte transfer happens this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Start address of a burst |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the current address |
| eng_start | output | 1 | Single-cycle run request |
| eng_dir | output | 1 | Direction of the launched run |
| eng_abort | output | 1 | Single-cycle cancel request |
| eng_key | output | 128 | Written (initial) key |
| eng_din | output | 128 | Data page contents |
| eng_done | input | 1 | Engine finished a run |
| eng_result | input | 128 | Result block, valid with eng_done |
| eng_lrk | input | 128 | Last round key, valid with eng_done |

## Verification
The hardest case to reach is a control register access that falls in the same cycle the engine reports done. Abort must win, and neither the data page nor the readable key may change. The stimulus launches a run and then reads 0x83 after a delay that steps through every offset from zero to past the engine latency, so one pass lands exactly on the done cycle. A behavioural model judges every read and every engine handshake in every pass.

// File: rtl/aesreg_pkg.sv
package aesreg_pkg;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_DATA = 3'd0;
    localparam mode_t MODE_KEY  = 3'd1;

    typedef struct packed {
        mode_t mode;
        logic  dir;
    } ctrl_t;

    // Control byte: start(7, reads 0) mode(6:4) dir(3) zero(2:1) busy(0)
    function automatic logic [7:0] ctrl_byte(input ctrl_t c, input logic busy);
        return {1'b0, c.mode, c.dir, 2'b00, busy};
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.mode = b[6:4];
        c.dir  = b[3];
        return c;
    endfunction

endpackage

// File: rtl/aesreg_addr_seq.sv
module aesreg_addr_seq #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          first,
    input  logic          strobe,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] eff_addr
);
    logic [AW-1:0] next_q;

    assign eff_addr = first ? addr : next_q;

    always_ff @(posedge clk) begin
        if (rst)         next_q <= '0;
        else if (strobe) next_q <= eff_addr + AW'(1);
    end
endmodule

// File: rtl/aesreg_page.sv
module aesreg_page #(
    parameter int NB = 16,
    localparam int IW = $clog2(NB),
    localparam int BW = 8 * NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          load_en,
    input  logic [BW-1:0] load_blk,
    output logic [BW-1:0] blk
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (rst)
                b_q <= '0;
            else if (load_en)
                b_q <= load_blk[BW-1-8*i -: 8];
            else if (wr_en && wr_idx == IW'(i))
                b_q <= wr_byte;
        end
        assign blk[BW-1-8*i -: 8] = b_q;
    end
endmodule

// File: rtl/aesreg_run_ctl.sv
module aesreg_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic launch_req,
    input  logic launch_dir,
    input  logic abort_req,
    input  logic done,
    output logic busy,
    output logic eng_start,
    output logic eng_abort,
    output logic run_dir,
    output logic capture
);
    assign capture = busy && done && !abort_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            run_dir   <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            if (busy && abort_req) begin
                busy      <= 1'b0;
                eng_abort <= 1'b1;
            end else if (busy && done) begin
                busy <= 1'b0;
            end else if (!busy && launch_req) begin
                busy      <= 1'b1;
                eng_start <= 1'b1;
                run_dir   <= launch_dir;
            end
        end
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy && $past(!busy && launch_req)); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R5
    AST_ABORT_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> !busy && $past(busy && abort_req)); // R8
    AST_BUSY_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        busy && launch_req |=> !eng_start); // R9
endmodule

// File: rtl/aesreg_frontend.sv
module aesreg_frontend
    import aesreg_pkg::*;
#(
    parameter int         BLK_BYTES = 16,
    parameter logic [7:0] BASE      = 8'h82,
    localparam int        BLK_BITS  = 8 * BLK_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_first,
    input  logic                bus_strobe,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                eng_start,
    output logic                eng_dir,
    output logic                eng_abort,
    output logic [BLK_BITS-1:0] eng_key,
    output logic [BLK_BITS-1:0] eng_din,
    input  logic                eng_done,
    input  logic [BLK_BITS-1:0] eng_result,
    input  logic [BLK_BITS-1:0] eng_lrk
);
    localparam int         IW     = $clog2(BLK_BYTES);
    localparam logic [7:0] A_CTRL = BASE + 8'd1;
    localparam logic [7:0] A_WIN  = BASE + 8'd2;
    localparam logic [7:0] A_MIR  = A_WIN + 8'(BLK_BYTES);

    logic [7:0]          eff;
    logic                hit_ctrl, hit_mir, hit_win, wr;
    logic [IW-1:0]       widx;
    ctrl_t               ctrl_q;
    logic                busy, capture, launch_req, abort_req;
    logic [BLK_BITS-1:0] key_blk, data_blk, lrk_q, rd_blk;
    logic                have_lrk;

    aesreg_addr_seq #(.AW(8)) u_addr (
        .clk(clk), .rst(rst), .first(bus_first), .strobe(bus_strobe),
        .addr(bus_addr), .eff_addr(eff)
    );

    assign hit_ctrl = (eff == A_CTRL);
    assign hit_mir  = (eff == A_MIR);
    assign hit_win  = (eff >= A_WIN) && (eff < A_MIR);
    assign widx     = IW'(eff - A_WIN);
    assign wr       = bus_strobe && bus_we;

    assign launch_req = wr && hit_mir && bus_wdata[7];
    assign abort_req  = bus_strobe && hit_ctrl;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr && (hit_ctrl || hit_mir))
            ctrl_q <= ctrl_from_byte(bus_wdata);
    end

    aesreg_run_ctl u_run (
        .clk(clk), .rst(rst),
        .launch_req(launch_req), .launch_dir(bus_wdata[3]),
        .abort_req(abort_req), .done(eng_done),
        .busy(busy), .eng_start(eng_start), .eng_abort(eng_abort),
        .run_dir(eng_dir), .capture(capture)
    );

    aesreg_page #(.NB(BLK_BYTES)) u_key (
        .clk(clk), .rst(rst),
        .wr_en(wr && hit_win && !busy && ctrl_q.mode == MODE_KEY),
        .wr_idx(widx), .wr_byte(bus_wdata),
        .load_en(1'b0), .load_blk('0),
        .blk(key_blk)
    );

    aesreg_page #(.NB(BLK_BYTES)) u_data (
        .clk(clk), .rst(rst),
        .wr_en(wr && hit_win && !busy && ctrl_q.mode == MODE_DATA),
        .wr_idx(widx), .wr_byte(bus_wdata),
        .load_en(capture), .load_blk(eng_result),
        .blk(data_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lrk_q    <= '0;
            have_lrk <= 1'b0;
        end else if (capture) begin
            lrk_q    <= eng_lrk;
            have_lrk <= 1'b1;
        end
    end

    assign eng_key = key_blk;
    assign eng_din = data_blk;

    always_comb begin
        rd_blk    = '0;
        bus_rdata = '0;
        if (ctrl_q.mode == MODE_KEY)       rd_blk = have_lrk ? lrk_q : key_blk;
        else if (ctrl_q.mode == MODE_DATA) rd_blk = data_blk;
        if (hit_ctrl || hit_mir)
            bus_rdata = ctrl_byte(ctrl_q, busy);
        else if (hit_win)
            bus_rdata = 8'(rd_blk >> (8 * (BLK_BYTES - 1 - int'(widx))));
    end

    AST_DATA_HELD_RUN: assert property (@(posedge clk) disable iff (rst)
        busy && !capture |=> $stable(data_blk)); // R9
    AST_KEY_HELD_RUN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(key_blk)); // R7
    AST_ABORT_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> $stable(lrk_q) && $stable(data_blk)); // R8
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !busy && eng_done |=> $stable(lrk_q)); // R6
endmodule

// File: tb/aesreg_frontend_bench.sv
`timescale 1ns/100ps
module aesreg_frontend_bench;
    localparam int LAT = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic b_first = 0, b_strobe = 0, b_we = 0;
    logic [7:0] b_addr = 0, b_wdata = 0;
    logic [7:0] b_rdata;
    logic eng_start, eng_dir, eng_abort;
    logic [127:0] eng_key, eng_din;
    logic e_done_r = 0, stray = 0;
    logic eng_done;
    logic [127:0] e_res = 0, e_lrk = 0;
    assign eng_done = e_done_r | stray;

    int checks = 0, fails = 0;

    aesreg_frontend u_aesreg_frontend (
        .clk(clk), .rst(rst),
        .bus_first(b_first), .bus_strobe(b_strobe), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .eng_start(eng_start), .eng_dir(eng_dir), .eng_abort(eng_abort),
        .eng_key(eng_key), .eng_din(eng_din),
        .eng_done(eng_done), .eng_result(e_res), .eng_lrk(e_lrk)
    );

    function automatic logic [127:0] f_res(input logic [127:0] d, input logic [127:0] k, input logic dr);
        return d ^ k ^ {16{dr ? 8'hC3 : 8'h3C}};
    endfunction
    function automatic logic [127:0] f_lrk(input logic [127:0] k);
        return {k[119:0], k[127:120]} ^ 128'h1;
    endfunction

    // stand-in engine, fixed latency
    int e_cnt = 0;
    logic [127:0] lat_din = 0, lat_key = 0;
    logic lat_dir = 0;
    always @(posedge clk) begin
        e_done_r <= 1'b0;
        if (rst) e_cnt <= 0;
        else if (eng_abort) e_cnt <= 0;
        else if (eng_start) begin
            e_cnt <= LAT; lat_din <= eng_din; lat_key <= eng_key; lat_dir <= eng_dir;
        end else if (e_cnt == 1) begin
            e_cnt <= 0; e_done_r <= 1'b1;
            e_res <= f_res(lat_din, lat_key, lat_dir);
            e_lrk <= f_lrk(lat_key);
        end else if (e_cnt > 1) e_cnt <= e_cnt - 1;
    end

    // behavioural reference model
    logic [2:0] m_mode; logic m_dir, m_rdir, m_busy, m_have, m_start, m_abort;
    logic [7:0] m_addr; logic [127:0] m_key, m_data, m_lrk;

    function automatic logic [7:0] m_read(input logic [7:0] e);
        logic [127:0] src;
        int wi;
        if (e == 8'h83 || e == 8'h94) return {1'b0, m_mode, m_dir, 2'b00, m_busy};
        if (e >= 8'h84 && e <= 8'h93) begin
            wi = int'(e) - 'h84;
            if (m_mode == 3'd1) src = m_have ? m_lrk : m_key;
            else if (m_mode == 3'd0) src = m_data;
            else return 8'h00;
            return src[127-8*wi -: 8];
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin : mdl
        logic [7:0] e;
        int wi;
        if (rst) begin
            m_mode <= 0; m_dir <= 0; m_rdir <= 0; m_busy <= 0; m_have <= 0;
            m_start <= 0; m_abort <= 0; m_addr <= 0; m_key <= 0; m_data <= 0; m_lrk <= 0;
        end else begin
            m_start <= 0; m_abort <= 0;
            e = b_first ? b_addr : m_addr;
            if (b_strobe) m_addr <= e + 8'd1;
            if (m_busy && b_strobe && e == 8'h83) begin
                m_busy <= 0; m_abort <= 1;
            end else if (m_busy && eng_done) begin
                m_data <= e_res; m_lrk <= e_lrk; m_have <= 1; m_busy <= 0;
            end
            if (b_strobe && b_we) begin
                if (e == 8'h83 || e == 8'h94) begin m_mode <= b_wdata[6:4]; m_dir <= b_wdata[3]; end
                if (e == 8'h94 && b_wdata[7] && !m_busy) begin
                    m_start <= 1; m_busy <= 1; m_rdir <= b_wdata[3];
                end
                if (e >= 8'h84 && e <= 8'h93 && !m_busy) begin
                    wi = int'(e) - 'h84;
                    if (m_mode == 3'd1) m_key[127-8*wi -: 8] <= b_wdata;
                    else if (m_mode == 3'd0) m_data[127-8*wi -: 8] <= b_wdata;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // engine handshake compared against the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5/R8 handshake", {eng_start, eng_abort}, {m_start, m_abort});
            if (m_start && eng_start)
                chk("R5 launch operands", {eng_dir, eng_key, eng_din}, {m_rdir, m_key, m_data});
        end
    end

    task automatic cyc(input logic f, input logic [7:0] a, input logic s, input logic w,
                       input logic [7:0] d, input string tag, output logic [7:0] got);
        @(negedge clk);
        b_first = f; b_addr = a; b_strobe = s; b_we = w; b_wdata = d;
        #1;
        got = b_rdata;
        if (s && !w) chk(tag, got, m_read(f ? a : m_addr));
    endtask

    task automatic wr(input logic f, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] g;
        cyc(f, a, 1'b1, 1'b1, d, "", g);
    endtask
    task automatic rd(input logic f, input logic [7:0] a, input string tag, output logic [7:0] g);
        cyc(f, a, 1'b1, 1'b0, 8'h00, tag, g);
    endtask
    task automatic idle(input int n);
        logic [7:0] g;
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "", g);
    endtask
    task automatic wr_blk(input logic [127:0] blk);
        for (int i = 0; i < 16; i++) wr(1'b0, 8'h00, blk[127-8*i -: 8]);
    endtask
    task automatic rd_blk(input string tag, output logic [127:0] blk);
        logic [7:0] g;
        for (int i = 0; i < 16; i++) begin
            rd(i == 0, 8'h84, tag, g);
            blk[127-8*i -: 8] = g;
        end
    endtask

    logic done_flag = 0;
    initial begin
        #1000000;
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        logic [127:0] K, D1, r1, r2, snap, blk;
        K  = 128'h00112233_44556677_8899aabb_ccddeeff;
        D1 = 128'h3243f6a8_885a308d_313198a2_e0370734;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R10 reset state, R1 reserved address
        rd(1, 8'h83, "R10 ctrl after reset", g); chk("R10 ctrl zero", g, 0);
        rd(1, 8'h82, "R1 reserved", g);          chk("R1 reserved reads 0", g, 0);
        rd_blk("R10 data page", blk);            chk("R10 data zero", blk, 0);

        // key load in key mode; readback before any run is the written key
        wr(1, 8'h83, 8'h10); wr_blk(K);
        rd_blk("R7 key readback", blk); chk("R7 initial key visible", blk, K);
        rd(1, 8'h94, "R2 mirror", g);   chk("R2 mirror = ctrl", g, 8'h10);

        // R4 one burst: control, data, start
        wr(1, 8'h83, 8'h00); wr_blk(D1); wr(0, 8'h00, 8'h80);
        idle(LAT + 3);
        chk("R4 burst loaded data", lat_din, D1);
        chk("R5 encrypt dir", {31'd0, lat_dir}, 0);
        rd(1, 8'h94, "R2 start reads 0", g); chk("R2 start bit reads 0", g, 8'h00);
        r1 = f_res(D1, K, 1'b0);
        rd_blk("R6 result", blk); chk("R6 result in data page", blk, r1);

        // R7 last round key exposed in key mode
        wr(1, 8'h94, 8'h10);
        rd_blk("R7 lrk", blk); chk("R7 last round key", blk, f_lrk(K));

        // R9 busy guards, R5 decrypt, R7 key reuse
        wr(1, 8'h83, 8'h00); wr(1, 8'h94, 8'h88);
        rd(1, 8'h94, "R9 busy bit", g); chk("R9 busy visible", g, 8'h09);
        wr(1, 8'h84, 8'hFF);
        wr(1, 8'h94, 8'h80);
        idle(LAT + 3);
        chk("R7 initial key reused", lat_key, K);
        chk("R5 decrypt dir", {31'd0, lat_dir}, 1);
        r2 = f_res(r1, K, 1'b1);
        rd_blk("R9 data after busy writes", blk); chk("R9 writes dropped, R6 result", blk, r2);

        // R8 abort sweep across every offset, including the done cycle
        for (int k = 0; k <= LAT + 3; k++) begin
            rd_blk("R8 pre", snap);
            wr(1, 8'h94, 8'h80);
            idle(k);
            rd(1, 8'h83, "R8 abort access", g);
            idle(LAT + 3);
            rd(1, 8'h94, "R8 idle after", g); chk("R8 busy cleared", {120'd0, g}, 0);
            rd_blk("R8 post", blk);
            if (k == 0) chk("R8 data kept after abort", blk, snap);
        end

        // R6 stray done while idle
        rd_blk("R6 pre stray", snap);
        @(negedge clk); stray = 1; @(negedge clk); stray = 0;
        rd_blk("R6 stray done", blk); chk("R6 idle done ignored", blk, snap);

        // R1 out-of-range writes
        wr(1, 8'h80, 8'hFF); wr(1, 8'h95, 8'hFF); wr(1, 8'h82, 8'hFF);
        rd(1, 8'h95, "R1 above window", g); chk("R1 0x95 reads 0", g, 0);
        rd(1, 8'h82, "R1 reserved write", g); chk("R1 0x82 still 0", g, 0);
        rd(1, 8'h83, "R1 ctrl intact", g); chk("R1 ctrl unchanged", g, 8'h00);

        // R3 undefined mode makes the window inert
        wr(1, 8'h83, 8'h20); wr(1, 8'h84, 8'h55);
        rd(1, 8'h84, "R3 inert window", g); chk("R3 mode 2 reads 0", g, 0);
        wr(1, 8'h83, 8'h00);
        rd_blk("R3 data untouched", blk); chk("R3 data page kept", blk, snap);

        // R10 reset clears everything
        @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
        wr(1, 8'h83, 8'h10);
        rd_blk("R10 key after reset", blk); chk("R10 keys cleared", blk, 0);
        wr(1, 8'h83, 8'h00);
        rd_blk("R10 data after reset", blk); chk("R10 data cleared", blk, 0);

        idle(2);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule